// File: doc/BRIEF.md
# Interrupt Pending/Active State Tracker

This block holds the service state of a bank of interrupt lines for a nested interrupt controller. Each line is in one of four states: inactive, pending, active, or active-and-pending. The state is reported as two flags per line, `pend_o` and `act_o`. Each line has a configuration bit that selects level-sensitive or pulse behaviour. Three strobes move a line between states: the core entering the line's handler, the core returning from it, and a software write that clears the pending flag.

The raw request signal first passes through a synchroniser. A level-sensitive line follows the synchronised signal. When the handler returns, the line samples the signal again to decide whether it is still pending. A pulse line reacts only to rising edges of the synchronised signal, so a pulse that arrives during the handler is recorded and serviced again after the return. The parameter `NL` sets how many independent lines are built side by side. Arbitration between lines and the core handshake stay outside the block.

Top module: `irq_track_bank`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every line reads `pend_o`=0 and `act_o`=0 (inactive).
- R2: `cfg_level[i]`=1 selects level behaviour. An inactive level line whose `irq_raw[i]` is held high shows `pend_o[i]`=1 on the third rising clock edge after the input change. There are two synchroniser stages and then the state register.
- R3: A `hnd_enter[i]` pulse on a pending line sets `act_o[i]`=1 and clears `pend_o[i]` on the next edge. On a pulse line this holds when no new rising edge arrives in the same cycle.
- R4: A pending line stays pending until handler entry or a clear write, even after its input falls. An entry strobe on a line that is not pending has no effect. A return strobe on a line that is not active has no effect.
- R5: On `hnd_return[i]` for an active level line, the line becomes pending if the synchronised signal is high, and inactive if it is low.
- R6: `cfg_level[i]`=0 selects pulse behaviour. A rising edge of the synchronised signal makes an inactive pulse line pending. A rising edge while the line is active makes it active-and-pending. A return from active-and-pending leaves the line pending.
- R7: A pulse line that saw no rising edge during its handler becomes inactive on return.
- R8: A clear write on a level line has no effect while the synchronised signal is high. When the signal is low, the write clears `pend_o[i]`.
- R9: A clear write on a pulse line turns pending into inactive, and turns active-and-pending into active.
- R10: When `hnd_enter[i]` and `clr_pend[i]` arrive in the same cycle on a pending line, entry wins and the line becomes active.
- R11: A level line that is active does not become pending while its signal stays high. The signal is looked at again only on return.
- R12: Lines are independent: strobes and inputs of one line never change the flags of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | NL | Asynchronous interrupt request inputs |
| cfg_level | input | NL | 1 = level-sensitive, 0 = pulse |
| hnd_enter | input | NL | Handler entry strobe per line |
| hnd_return | input | NL | Handler return strobe per line |
| clr_pend | input | NL | Software clear-pending write strobe per line |
| pend_o | output | NL | Pending flag per line |
| act_o | output | NL | Active flag per line |

## Verification
The hardest state to reach is active-and-pending on a pulse line. The stimulus must first raise a pulse, wait out the synchroniser latency, enter the handler, and then send a second full low-high-low pulse before any return strobe. The bench does exactly that with a pulse task that holds the input long enough for the edge to pass through both stages. It then checks both exits from that state: a clear write, which leaves the line active, and a return, which leaves it pending. For level lines, the bench lowers the input and waits for the synchroniser to settle before the return strobe, so that the resampling sees the intended value.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

    typedef enum logic {
        TRIG_PULSE = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic act;
        logic pend;
    } line_st_t;

    localparam line_st_t ST_IDLE = '{act: 1'b0, pend: 1'b0};

    // Next state of one line from its current state and this cycle's events.
    function automatic line_st_t line_step(
        line_st_t cur,
        trig_e    mode,
        logic     sig,
        logic     rise,
        logic     enter,
        logic     ret,
        logic     clr
    );
        line_st_t nxt;
        nxt = cur;
        if (enter && cur.pend) begin
            nxt.act  = 1'b1;
            nxt.pend = (mode == TRIG_PULSE) ? rise : 1'b0;
        end else if (ret && cur.act) begin
            nxt.act  = 1'b0;
            nxt.pend = (mode == TRIG_LEVEL) ? sig : (cur.pend | rise);
        end else if (mode == TRIG_LEVEL) begin
            nxt.pend = (cur.pend && !(clr && !sig)) || (sig && !cur.act);
        end else begin
            nxt.pend = rise || (cur.pend && !clr);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sync_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign sync_o = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_state_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_sel,
    input  logic sig,
    input  logic rise,
    input  logic enter,
    input  logic ret,
    input  logic clr,
    output logic pend,
    output logic act
);
    line_st_t st_q, st_d;
    trig_e    mode;

    assign mode = level_sel ? TRIG_LEVEL : TRIG_PULSE;

    always_comb begin
        st_d = line_step(st_q, mode, sig, rise, enter, ret, clr);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign act  = st_q.act;
endmodule

// File: rtl/irq_track_bank.sv
module irq_track_bank #(
    parameter int NL          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] irq_raw,
    input  logic [NL-1:0] cfg_level,
    input  logic [NL-1:0] hnd_enter,
    input  logic [NL-1:0] hnd_return,
    input  logic [NL-1:0] clr_pend,
    output logic [NL-1:0] pend_o,
    output logic [NL-1:0] act_o
);
    logic [NL-1:0] sig_s;
    logic [NL-1:0] rise_s;

    generate
        for (genvar i = 0; i < NL; i++) begin : g_line
            irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .din    (irq_raw[i]),
                .sync_o (sig_s[i]),
                .rise_o (rise_s[i])
            );
            irq_line_fsm u_fsm (
                .clk       (clk),
                .rst       (rst),
                .level_sel (cfg_level[i]),
                .sig       (sig_s[i]),
                .rise      (rise_s[i]),
                .enter     (hnd_enter[i]),
                .ret       (hnd_return[i]),
                .clr       (clr_pend[i]),
                .pend      (pend_o[i]),
                .act       (act_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/irq_track_chk.sv
module irq_track_chk #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NL-1:0] cfg_level,
    input logic [NL-1:0] hnd_enter,
    input logic [NL-1:0] hnd_return,
    input logic [NL-1:0] clr_pend,
    input logic [NL-1:0] pend_o,
    input logic [NL-1:0] act_o
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && act_o == '0));

    generate
        for (genvar i = 0; i < NL; i++) begin : g_chk
            p_enter_act_r3: assert property (@(posedge clk) disable iff (rst)
                (hnd_enter[i] && pend_o[i]) |=> act_o[i]);

            p_pend_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (pend_o[i] && !hnd_enter[i] && !clr_pend[i]) |=> pend_o[i]);

            p_act_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (act_o[i] && !hnd_return[i]) |=> act_o[i]);

            p_return_drop_r5: assert property (@(posedge clk) disable iff (rst)
                (hnd_return[i] && act_o[i] && !(hnd_enter[i] && pend_o[i])) |=> !act_o[i]);

            p_pulse_clr_r9: assert property (@(posedge clk) disable iff (rst)
                (!cfg_level[i] && clr_pend[i] && pend_o[i] && !act_o[i] && !hnd_enter[i])
                |=> !act_o[i]);

            p_enter_wins_r10: assert property (@(posedge clk) disable iff (rst)
                (hnd_enter[i] && clr_pend[i] && pend_o[i]) |=> act_o[i]);
        end
    endgenerate
endmodule

bind irq_track_bank irq_track_chk #(.NL(NL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_level  (cfg_level),
    .hnd_enter  (hnd_enter),
    .hnd_return (hnd_return),
    .clr_pend   (clr_pend),
    .pend_o     (pend_o),
    .act_o      (act_o)
);

// File: tb/tb_irq_track_bank.sv
`timescale 1ns/1ps
module tb_irq_track_bank;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] irq_raw, cfg_level, hnd_enter, hnd_return, clr_pend;
    logic [NL-1:0] pend_o, act_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_track_bank #(.NL(NL)) dut (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .cfg_level(cfg_level),
        .hnd_enter(hnd_enter), .hnd_return(hnd_return), .clr_pend(clr_pend),
        .pend_o(pend_o), .act_o(act_o)
    );

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string req, input int line, input logic ep, input logic ea);
        total++;
        if (pend_o[line] !== ep || act_o[line] !== ea) begin
            bad++;
            $display("FAIL %s line%0d: pend/act=%b%b expected %b%b",
                     req, line, pend_o[line], act_o[line], ep, ea);
        end
    endtask

    task automatic strobe_enter(input int l);
        hnd_enter[l] = 1'b1; tick(1); hnd_enter[l] = 1'b0;
    endtask
    task automatic strobe_return(input int l);
        hnd_return[l] = 1'b1; tick(1); hnd_return[l] = 1'b0;
    endtask
    task automatic strobe_clr(input int l);
        clr_pend[l] = 1'b1; tick(1); clr_pend[l] = 1'b0;
    endtask
    task automatic pulse(input int l);
        irq_raw[l] = 1'b1; tick(2); irq_raw[l] = 1'b0; tick(3);
    endtask

    task automatic t_reset;
        rst = 1'b1; tick(2);
        for (int l = 0; l < NL; l++) chk("R1", l, 1'b0, 1'b0);
        rst = 1'b0; tick(1);
        chk("R1", 0, 1'b0, 1'b0);
    endtask

    task automatic t_level_flow;
        irq_raw[0] = 1'b1; tick(2);
        chk("R2 early", 0, 1'b0, 1'b0);
        tick(1);
        chk("R2", 0, 1'b1, 1'b0);
        strobe_return(0);
        chk("R4 stray return", 0, 1'b1, 1'b0);
        strobe_enter(0);
        chk("R3", 0, 1'b0, 1'b1);
        tick(3);
        chk("R11", 0, 1'b0, 1'b1);
        strobe_return(0);
        chk("R5 high", 0, 1'b1, 1'b0);
        strobe_enter(0);
        irq_raw[0] = 1'b0; tick(3);
        strobe_return(0);
        chk("R5 low", 0, 1'b0, 1'b0);
        strobe_enter(0);
        chk("R4 stray enter", 0, 1'b0, 1'b0);
    endtask

    task automatic t_level_clear;
        irq_raw[0] = 1'b1; tick(3);
        strobe_clr(0);
        chk("R8 held", 0, 1'b1, 1'b0);
        irq_raw[0] = 1'b0; tick(3);
        chk("R4 hold", 0, 1'b1, 1'b0);
        strobe_clr(0);
        chk("R8 low", 0, 1'b0, 1'b0);
    endtask

    task automatic t_pulse_flow;
        pulse(1);
        chk("R6 idle", 1, 1'b1, 1'b0);
        strobe_enter(1);
        chk("R3 pulse", 1, 1'b0, 1'b1);
        pulse(1);
        chk("R6 active", 1, 1'b1, 1'b1);
        strobe_clr(1);
        chk("R9 actpend", 1, 1'b0, 1'b1);
        pulse(1);
        strobe_return(1);
        chk("R6 return", 1, 1'b1, 1'b0);
        strobe_enter(1);
        strobe_return(1);
        chk("R7", 1, 1'b0, 1'b0);
        pulse(1);
        strobe_clr(1);
        chk("R9 pend", 1, 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        irq_raw[0] = 1'b1; tick(3);
        hnd_enter[0] = 1'b1; clr_pend[0] = 1'b1; tick(1);
        hnd_enter[0] = 1'b0; clr_pend[0] = 1'b0;
        chk("R10", 0, 1'b0, 1'b1);
        irq_raw[0] = 1'b0; tick(3);
        strobe_return(0);
        chk("R10 exit", 0, 1'b0, 1'b0);
    endtask

    task automatic t_independent;
        irq_raw[2] = 1'b1; tick(1);
        pulse(3);
        chk("R12 l2", 2, 1'b1, 1'b0);
        chk("R12 l3", 3, 1'b1, 1'b0);
        strobe_enter(2);
        chk("R12 l2 act", 2, 1'b0, 1'b1);
        chk("R12 l3 same", 3, 1'b1, 1'b0);
        strobe_clr(3);
        chk("R12 l2 same", 2, 1'b0, 1'b1);
        chk("R12 l3 clr", 3, 1'b0, 1'b0);
        chk("R12 l0", 0, 1'b0, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        irq_raw = '0; cfg_level = 4'b0101;
        hnd_enter = '0; hnd_return = '0; clr_pend = '0;
        tick(1);
        t_reset();
        t_level_flow();
        t_level_clear();
        t_pulse_flow();
        t_priority();
        t_independent();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule